// File: doc/BRIEF.md
# Lane Low-Power / High-Speed Mode Controller

This block owns the two single-ended low-power wires of every lane in a serial camera/display link: one clock lane and a parameterised number of data lanes. Outside high-speed (HS) operation it either receives the wire pair onto a user bus or drives a user bus onto the wires, lane by lane, as a direction input selects. It watches the wires for the low-power-to-HS entry sequence. When a lane has entered HS, it turns on that lane's HS enable, which switches on termination on a receiver or the differential driver on a transmitter. While a lane is in HS, both of its low-power wires are forced low.

The clock lane has its own HS enable, separate from the data lanes. The clock lane always enters HS first and leaves last. HS operation ends in any of three ways:
- an end-of-burst indication,
- a bad-check indication,
- a timeout counted in byte clocks, which restarts whenever a sync indication arrives.

After an exit, every lane goes back to low-power receive. Entry detection re-arms only once each lane has shown the stop state again.

The sequencer is a five-state machine:
- SEQ_WAIT_STOP is the reset state. It moves to SEQ_ARMED when every lane holds LP-11.
- SEQ_ARMED moves to SEQ_CLK_HS when the clock lane completes the entry sequence.
- SEQ_CLK_HS moves to SEQ_DATA_HS when every data lane completes the entry sequence. It moves to SEQ_CLK_TAIL on end-of-burst or error.
- SEQ_DATA_HS moves to SEQ_CLK_TAIL on end-of-burst, error or timeout.
- SEQ_CLK_TAIL returns to SEQ_WAIT_STOP after TAIL_CYC cycles.

Each lane also has a four-state entry detector:
- DET_IDLE moves to DET_STOP when LP-11 has been held for HOLD samples.
- DET_STOP moves to DET_RQST when LP-01 has been held for HOLD samples.
- DET_RQST moves to DET_DONE when LP-00 has been held for HOLD samples.
- Any out-of-order value sends the detector back to DET_IDLE.
- DET_DONE is sticky until the sequencer clears the detector.

Top module: `lpmode_lane_ctrl`

## Requirements
- R1: Lane k occupies bits [2k+1:2k] of every wire bus; lane 0 is the clock lane and lanes 1..NDATA are data lanes. Within a lane, bit 1 is the P wire and bit 0 the N wire, so LP-01 means P low and N high (value 2'b01).
- R2: A lane that is not in HS and has direction 0 releases its wires (output enables 00) and shows the sampled wire pair on its user receive bus in the same cycle.
- R3: A lane that is not in HS and has direction 1 enables both wire drivers (11), drives its user transmit pair onto the wires, and reads 00 on its user receive bus.
- R4: A lane in HS (the clock lane while its HS enable is high, a data lane while the data HS enable is high) drives both wires low with enables 11 and reads 00 on its receive bus, whatever its direction and transmit inputs are.
- R5: After reset both HS enables are low and the sequencer waits for the stop state.
- R6: With the clock lane holding LP-11, then LP-01, then LP-00, each for at least HOLD samples, the clock HS enable rises on the fourth rising edge after the first edge that samples LP-00.
- R7: Any other order (for example LP-11 straight to LP-00, a leg shorter than HOLD samples, or LP-10) returns the detector to idle, and the clock HS enable stays low.
- R8: The data HS enable rises only while the clock HS enable is already high, and only after every data lane has completed its own entry sequence. It rises on the fourth edge after the last data lane first samples LP-00.
- R9: End-of-burst or error drops the data HS enable at the sampling edge. The clock HS enable stays high for TAIL_CYC more edges and then drops.
- R10: In data HS, TIMEOUT consecutive cycles without sync end HS as in R9. A sync pulse restarts the count.
- R11: After an exit every lane returns to low-power behaviour. Entry re-arms only after every lane has held LP-11 for HOLD samples; until then an LP-01/LP-00 sequence has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock; samples the wires |
| rst_n | input | 1 | Asynchronous active-low reset |
| lpw_i | input | 2*(NDATA+1) | Sampled low-power wire pairs |
| lpw_o | output | 2*(NDATA+1) | Values driven onto the wires |
| lpw_oe_o | output | 2*(NDATA+1) | Per-wire tri-state enables (1 = drive) |
| lpw_dir_i | input | NDATA+1 | Per-lane direction: 0 receive, 1 transmit |
| usr_tx_i | input | 2*(NDATA+1) | User pairs to drive in transmit direction |
| usr_rx_o | output | 2*(NDATA+1) | Received pairs, valid in receive direction outside HS |
| burst_sync_i | input | 1 | Sync/header seen; restarts the timeout |
| burst_end_i | input | 1 | End-of-burst request |
| burst_err_i | input | 1 | Bad check value; leave HS |
| hs_clk_on_o | output | 1 | Clock lane HS enable (termination or HS driver; driver tri-stated when low) |
| hs_dat_on_o | output | 1 | Data lanes HS enable (termination or HS driver; driver tri-stated when low) |

## Verification
The wire multiplexing is combinational. The bench checks it one time unit after it drives new inputs at a falling edge, using random directions, transmit pairs and wire values; the expected values come from a bench function.

Entry needs three register stages: the wire sample, the detector state and the sequencer state. The HS enables are therefore checked both after the third edge (still low) and after the fourth edge (high), counted from the edge that first samples LP-00.

An exit request drops the data enable at the edge that samples the request. The clock enable is checked at TAIL_CYC-1 and at TAIL_CYC edges after that edge. The timeout is checked 255 and 256 edges after the last sync edge, so an off-by-one in either counter shows up as a mismatch.

// File: rtl/lpctl_pkg.sv
package lpctl_pkg;

    // Per-lane entry detector states
    typedef enum logic [1:0] {
        DET_IDLE,
        DET_STOP,
        DET_RQST,
        DET_DONE
    } det_state_e;

    // Lane-group HS sequencer states
    typedef enum logic [2:0] {
        SEQ_WAIT_STOP,
        SEQ_ARMED,
        SEQ_CLK_HS,
        SEQ_DATA_HS,
        SEQ_CLK_TAIL
    } seq_state_e;

    // Wire-pair codes, bit 1 = P wire, bit 0 = N wire
    localparam logic [1:0] LP_11 = 2'b11;
    localparam logic [1:0] LP_01 = 2'b01;
    localparam logic [1:0] LP_00 = 2'b00;

endpackage

// File: rtl/lp_pad_mux.sv
module lp_pad_mux (
    input  logic       hs_force_i,
    input  logic       dir_i,
    input  logic [1:0] tx_i,
    input  logic [1:0] pin_i,
    output logic [1:0] pin_o,
    output logic [1:0] pin_oe_o,
    output logic [1:0] rx_o
);

    always_comb begin
        pin_o    = 2'b00;
        pin_oe_o = 2'b00;
        rx_o     = 2'b00;
        if (hs_force_i) begin
            // HS: both wires held low, direction ignored
            pin_oe_o = 2'b11;
        end else if (dir_i) begin
            pin_oe_o = 2'b11;
            pin_o    = tx_i;
        end else begin
            rx_o     = pin_i;
        end
    end

endmodule

// File: rtl/lp_entry_detect.sv
module lp_entry_detect
    import lpctl_pkg::*;
#(
    parameter int HOLD = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr_i,
    input  logic [1:0] pin_i,
    output logic       stop_ok_o,
    output logic       done_o
);

    localparam int RW = $clog2(HOLD + 1);

    logic [1:0]    smp_q;
    logic [RW-1:0] run_q;
    det_state_e    st_q, st_d;
    logic          held;

    assign held = (run_q >= RW'(HOLD));

    // wire sample and run length of identical samples
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            smp_q <= LP_00;
            run_q <= '0;
        end else begin
            smp_q <= pin_i;
            if (pin_i != smp_q) begin
                run_q <= RW'(1);
            end else if (run_q != RW'(HOLD)) begin
                run_q <= run_q + RW'(1);
            end
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= DET_IDLE;
        else        st_q <= st_d;
    end

    // next state
    always_comb begin
        st_d = st_q;
        if (clr_i) begin
            st_d = DET_IDLE;
        end else begin
            unique case (st_q)
                DET_IDLE: begin
                    if (smp_q == LP_11 && held) st_d = DET_STOP;
                end
                DET_STOP: begin
                    if (smp_q == LP_01) begin
                        if (held) st_d = DET_RQST;
                    end else if (smp_q != LP_11) begin
                        st_d = DET_IDLE;
                    end
                end
                DET_RQST: begin
                    if (smp_q == LP_00) begin
                        if (held) st_d = DET_DONE;
                    end else if (smp_q != LP_01) begin
                        st_d = DET_IDLE;
                    end
                end
                DET_DONE: st_d = DET_DONE;
                default:  st_d = DET_IDLE;
            endcase
        end
    end

    // outputs
    always_comb begin
        stop_ok_o = (smp_q == LP_11) && held;
        done_o    = (st_q == DET_DONE);
    end

    // R6: completion is always preceded by an LP-00 sample on the pins
    assert_done_after_lp00_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_o) |-> ($past(pin_i) == LP_00));

    // R7: completion stays until cleared
    assert_done_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !clr_i) |=> done_o);

endmodule

// File: rtl/hs_sequencer.sv
module hs_sequencer
    import lpctl_pkg::*;
#(
    parameter int TIMEOUT  = 256,
    parameter int TAIL_CYC = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic all_stop_i,
    input  logic clk_done_i,
    input  logic data_done_i,
    input  logic sync_i,
    input  logic end_i,
    input  logic err_i,
    output logic hs_clk_on_o,
    output logic hs_dat_on_o,
    output logic clk_det_clr_o,
    output logic dat_det_clr_o
);

    localparam int CNT_MAX = (TIMEOUT > TAIL_CYC) ? TIMEOUT : TAIL_CYC;
    localparam int CW      = $clog2(CNT_MAX + 1);

    seq_state_e    st_q, st_d;
    logic [CW-1:0] cnt_q;
    logic          to_hit;
    logic          tail_done;

    assign to_hit    = !sync_i && (cnt_q == CW'(TIMEOUT - 1));
    assign tail_done = (cnt_q == CW'(TAIL_CYC - 1));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= SEQ_WAIT_STOP;
        else        st_q <= st_d;
    end

    // cycle counter: timeout in data HS, tail length in clock tail
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (st_q != st_d) begin
            cnt_q <= '0;
        end else if (st_q == SEQ_DATA_HS) begin
            cnt_q <= sync_i ? '0 : cnt_q + CW'(1);
        end else if (st_q == SEQ_CLK_TAIL) begin
            cnt_q <= cnt_q + CW'(1);
        end else begin
            cnt_q <= '0;
        end
    end

    // next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            SEQ_WAIT_STOP: if (all_stop_i)  st_d = SEQ_ARMED;
            SEQ_ARMED:     if (clk_done_i)  st_d = SEQ_CLK_HS;
            SEQ_CLK_HS: begin
                if (end_i || err_i)          st_d = SEQ_CLK_TAIL;
                else if (data_done_i)        st_d = SEQ_DATA_HS;
            end
            SEQ_DATA_HS: begin
                if (end_i || err_i || to_hit) st_d = SEQ_CLK_TAIL;
            end
            SEQ_CLK_TAIL:  if (tail_done)   st_d = SEQ_WAIT_STOP;
            default:                        st_d = SEQ_WAIT_STOP;
        endcase
    end

    // outputs
    always_comb begin
        hs_clk_on_o   = (st_q == SEQ_CLK_HS) || (st_q == SEQ_DATA_HS) ||
                        (st_q == SEQ_CLK_TAIL);
        hs_dat_on_o   = (st_q == SEQ_DATA_HS);
        clk_det_clr_o = (st_q == SEQ_WAIT_STOP);
        dat_det_clr_o = (st_q != SEQ_CLK_HS) && (st_q != SEQ_DATA_HS);
    end

    // R6: clock HS only follows a completed clock-lane entry
    assert_clk_entry_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hs_clk_on_o) |-> $past(clk_done_i));

    // R8: data HS rises only with the clock lane already in HS
    assert_clk_leads_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hs_dat_on_o) |-> ($past(hs_clk_on_o) && $past(data_done_i)));

    // R9: the clock lane leaves HS only after the data lanes
    assert_clk_trails_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(hs_clk_on_o) |-> ($past(!hs_dat_on_o) && !hs_dat_on_o));

    // R9/R10: data HS only ends on a request or a timeout
    assert_exit_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(hs_dat_on_o) |-> $past(end_i || err_i || !sync_i));

    // R10: the timeout count never reaches the limit in data HS
    assert_to_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == SEQ_DATA_HS) |-> (cnt_q < CW'(TIMEOUT)));

endmodule

// File: rtl/lpmode_lane_ctrl.sv
module lpmode_lane_ctrl
    import lpctl_pkg::*;
#(
    parameter int NDATA    = 2,
    parameter int HOLD     = 2,
    parameter int TIMEOUT  = 256,
    parameter int TAIL_CYC = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [2*(NDATA+1)-1:0] lpw_i,
    output logic [2*(NDATA+1)-1:0] lpw_o,
    output logic [2*(NDATA+1)-1:0] lpw_oe_o,
    input  logic [NDATA:0]         lpw_dir_i,
    input  logic [2*(NDATA+1)-1:0] usr_tx_i,
    output logic [2*(NDATA+1)-1:0] usr_rx_o,
    input  logic                   burst_sync_i,
    input  logic                   burst_end_i,
    input  logic                   burst_err_i,
    output logic                   hs_clk_on_o,
    output logic                   hs_dat_on_o
);

    localparam int NL = NDATA + 1;

    logic [NL-1:0] stop_ok;
    logic [NL-1:0] done;
    logic          clk_clr, dat_clr;
    logic          hs_clk, hs_dat;

    for (genvar g = 0; g < NL; g++) begin : g_lane
        logic force_hs;
        logic clr;
        if (g == 0) begin : g_clk
            assign force_hs = hs_clk;
            assign clr      = clk_clr;
        end else begin : g_dat
            assign force_hs = hs_dat;
            assign clr      = dat_clr;
        end

        lp_pad_mux u_pad (
            .hs_force_i (force_hs),
            .dir_i      (lpw_dir_i[g]),
            .tx_i       (usr_tx_i[2*g +: 2]),
            .pin_i      (lpw_i[2*g +: 2]),
            .pin_o      (lpw_o[2*g +: 2]),
            .pin_oe_o   (lpw_oe_o[2*g +: 2]),
            .rx_o       (usr_rx_o[2*g +: 2])
        );

        lp_entry_detect #(.HOLD(HOLD)) u_det (
            .clk       (clk),
            .rst_n     (rst_n),
            .clr_i     (clr),
            .pin_i     (lpw_i[2*g +: 2]),
            .stop_ok_o (stop_ok[g]),
            .done_o    (done[g])
        );
    end

    hs_sequencer #(.TIMEOUT(TIMEOUT), .TAIL_CYC(TAIL_CYC)) u_seq (
        .clk           (clk),
        .rst_n         (rst_n),
        .all_stop_i    (&stop_ok),
        .clk_done_i    (done[0]),
        .data_done_i   (&done[NL-1:1]),
        .sync_i        (burst_sync_i),
        .end_i         (burst_end_i),
        .err_i         (burst_err_i),
        .hs_clk_on_o   (hs_clk),
        .hs_dat_on_o   (hs_dat),
        .clk_det_clr_o (clk_clr),
        .dat_det_clr_o (dat_clr)
    );

    assign hs_clk_on_o = hs_clk;
    assign hs_dat_on_o = hs_dat;

    // R4: clock lane wires forced low while its HS enable is on
    assert_clk_forced_R4: assert property (@(posedge clk) disable iff (!rst_n)
        hs_clk_on_o |-> (lpw_oe_o[1:0] == 2'b11 && lpw_o[1:0] == 2'b00 &&
                         usr_rx_o[1:0] == 2'b00));

    // R4: last data lane forced low while data HS is on
    assert_dat_forced_R4: assert property (@(posedge clk) disable iff (!rst_n)
        hs_dat_on_o |-> (lpw_oe_o[2*NL-1 -: 2] == 2'b11 &&
                         lpw_o[2*NL-1 -: 2] == 2'b00));

    // R2: clock lane receive passes the wires through outside HS
    assert_clk_rx_pass_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!hs_clk_on_o && !lpw_dir_i[0]) |->
            (usr_rx_o[1:0] == lpw_i[1:0] && lpw_oe_o[1:0] == 2'b00));

    // R5: no HS on the first cycle after reset
    assert_reset_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (!hs_clk_on_o && !hs_dat_on_o));

endmodule

// File: tb/sim_lpmode_lane_ctrl.sv
module sim_lpmode_lane_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int NL         = 3;
    localparam int TAIL       = 8;

    logic            clk = 1'b0;
    logic            rst_n;
    logic [2*NL-1:0] lpw;
    logic [2*NL-1:0] lpw_o, lpw_oe, usr_rx, usr_tx;
    logic [NL-1:0]   dir;
    logic            sync, bend, berr;
    logic            hs_clk, hs_dat;

    int n_cmp = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lpmode_lane_ctrl u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .lpw_i        (lpw),
        .lpw_o        (lpw_o),
        .lpw_oe_o     (lpw_oe),
        .lpw_dir_i    (dir),
        .usr_tx_i     (usr_tx),
        .usr_rx_o     (usr_rx),
        .burst_sync_i (sync),
        .burst_end_i  (bend),
        .burst_err_i  (berr),
        .hs_clk_on_o  (hs_clk),
        .hs_dat_on_o  (hs_dat)
    );

    // expected {wire out, wire oe, user rx} of one lane
    function automatic logic [5:0] exp_pad(input logic hs, input logic d,
                                           input logic [1:0] tx, input logic [1:0] pin);
        if (hs)     return {2'b00, 2'b11, 2'b00};
        else if (d) return {tx,    2'b11, 2'b00};
        else        return {2'b00, 2'b00, pin};
    endfunction

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%0h exp=%0h t=%0t", req, act, exp, $time);
        end
    endtask

    task automatic check_pads(input string req);
        for (int l = 0; l < NL; l++) begin
            logic hs_l;
            hs_l = (l == 0) ? hs_clk : hs_dat;
            chk(req, {26'd0, lpw_o[2*l +: 2], lpw_oe[2*l +: 2], usr_rx[2*l +: 2]},
                {26'd0, exp_pad(hs_l, dir[l], usr_tx[2*l +: 2], lpw[2*l +: 2])});
        end
    endtask

    task automatic set_lane(input int l, input logic [1:0] v);
        lpw[2*l +: 2] = v;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog expired act=running exp=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd1729));
        rst_n = 1'b0; lpw = '1; dir = '0; usr_tx = '0;
        sync = 1'b0; bend = 1'b0; berr = 1'b0;
        tick(3);
        chk("R5 clk hs in reset", {31'd0, hs_clk}, 0);
        chk("R5 dat hs in reset", {31'd0, hs_dat}, 0);
        #1 check_pads("R2 reset receive");
        rst_n = 1'b1;
        tick(2);

        // R1: P wire is bit 1
        dir = 3'b001; usr_tx = 6'b000010;
        #1 chk("R1 P wire bit", {30'd0, lpw_o[1:0]}, 2'b10);
        tick(1);

        // R2 R3: random directions and data, clock lane parked in LP-11
        for (int i = 0; i < 80; i++) begin
            dir       = NL'($urandom);
            usr_tx    = (2*NL)'($urandom);
            lpw[5:2]  = 4'($urandom);
            lpw[1:0]  = 2'b11;
            #1 check_pads("R2 R3 random pads");
            tick(1);
        end
        chk("R7 no hs on random", {31'd0, hs_clk}, 0);
        dir = '0; usr_tx = '0; lpw = '1;
        tick(5);

        // R7: wrong orders
        set_lane(0, 2'b00); tick(6);
        chk("R7 11->00", {31'd0, hs_clk}, 0);
        set_lane(0, 2'b11); tick(5);
        set_lane(0, 2'b01); tick(1);
        set_lane(0, 2'b00); tick(6);
        chk("R7 short 01", {31'd0, hs_clk}, 0);
        set_lane(0, 2'b11); tick(5);
        set_lane(0, 2'b10); tick(5);
        set_lane(0, 2'b00); tick(6);
        chk("R7 10 leg", {31'd0, hs_clk}, 0);

        // R6: exact entry timing
        set_lane(0, 2'b11); tick(5);
        set_lane(0, 2'b01); tick(5);
        set_lane(0, 2'b00); tick(3);
        chk("R6 clk hs before edge 4", {31'd0, hs_clk}, 0);
        tick(1);
        chk("R6 clk hs at edge 4", {31'd0, hs_clk}, 1);
        chk("R8 dat hs off", {31'd0, hs_dat}, 0);

        // R4: forcing overrides direction on the clock lane
        dir = '1; usr_tx = '1;
        #1 check_pads("R4 clk forced");
        chk("R4 clk lane low", {26'd0, lpw_o[1:0], lpw_oe[1:0], usr_rx[1:0]}, 6'b001100);
        dir = '0; usr_tx = '0;

        // R8: both data lanes must complete
        set_lane(1, 2'b01); tick(5);
        set_lane(1, 2'b00); tick(5);
        chk("R8 one data lane only", {31'd0, hs_dat}, 0);
        set_lane(2, 2'b01); tick(5);
        set_lane(2, 2'b00); tick(3);
        chk("R8 dat hs before edge 4", {31'd0, hs_dat}, 0);
        tick(1);
        chk("R8 dat hs at edge 4", {31'd0, hs_dat}, 1);
        dir = 3'b110; usr_tx = 6'b111100;
        #1 check_pads("R4 data forced");
        dir = '0; usr_tx = '0;

        // R10: sync keeps HS alive, then timeout
        for (int k = 0; k < 5; k++) begin
            sync = 1'b1; tick(1); sync = 1'b0; tick(99);
            chk("R10 alive with sync", {31'd0, hs_dat}, 1);
        end
        sync = 1'b1; tick(1); sync = 1'b0;
        tick(254);
        chk("R10 before timeout", {31'd0, hs_dat}, 1);
        tick(1);
        chk("R10 at limit-1", {31'd0, hs_dat}, 1);
        tick(1);
        chk("R10 timeout dat off", {31'd0, hs_dat}, 0);
        chk("R9 clk still on", {31'd0, hs_clk}, 1);
        tick(TAIL - 1);
        chk("R9 clk tail", {31'd0, hs_clk}, 1);
        tick(1);
        chk("R9 clk off after tail", {31'd0, hs_clk}, 0);

        // R11: back to receive, re-arm needs LP-11
        #1 check_pads("R11 receive after exit");
        set_lane(1, 2'b11); set_lane(2, 2'b11);
        set_lane(0, 2'b01); tick(5);
        set_lane(0, 2'b00); tick(6);
        chk("R11 no entry without stop", {31'd0, hs_clk}, 0);
        set_lane(0, 2'b11); tick(5);
        set_lane(0, 2'b01); tick(5);
        set_lane(0, 2'b00); tick(4);
        chk("R11 entry after stop", {31'd0, hs_clk}, 1);

        // R9: error in clock-only HS
        berr = 1'b1; tick(1); berr = 1'b0;
        chk("R9 err clk on", {31'd0, hs_clk}, 1);
        chk("R9 err dat off", {31'd0, hs_dat}, 0);
        tick(TAIL - 1);
        chk("R9 err tail", {31'd0, hs_clk}, 1);
        tick(1);
        chk("R9 err clk off", {31'd0, hs_clk}, 0);

        // R9: end-of-burst in data HS
        lpw = '1; tick(5);
        set_lane(0, 2'b01); tick(5);
        set_lane(0, 2'b00); tick(5);
        chk("R6 second entry", {31'd0, hs_clk}, 1);
        set_lane(1, 2'b01); set_lane(2, 2'b01); tick(5);
        set_lane(1, 2'b00); set_lane(2, 2'b00); tick(5);
        chk("R8 second data entry", {31'd0, hs_dat}, 1);
        bend = 1'b1; tick(1); bend = 1'b0;
        chk("R9 end dat off", {31'd0, hs_dat}, 0);
        chk("R9 end clk on", {31'd0, hs_clk}, 1);
        tick(TAIL - 1);
        chk("R9 end tail", {31'd0, hs_clk}, 1);
        tick(1);
        chk("R9 end clk off", {31'd0, hs_clk}, 0);
        #1 check_pads("R11 final receive");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule